// File: doc/BRIEF.md
# Chord Arpeggiator Note Sequencer

This block cycles through the tones of a chord, moving one tone forward on each pulse of an external advance signal. The root is always part of the cycle. The third, the fifth and an upper tone each have their own enable. One select input picks a major or a minor third. Another picks a seventh or a full octave for the upper tone. The output is a 7-bit note code: the root code plus the semitone offset of the tone that is currently active.

The sequence can run in two modes. In ascending-only mode it climbs to the highest enabled tone and then wraps back to the root. In up-down mode it climbs, then comes back down through the lower enabled tones and returns to the root. Neither the top tone nor the root is repeated at a turning point. Direction is not held in a separate flag. It is carried by two extra states, a descending fifth and a descending third.

The advance input may be asynchronous to the clock. It passes through a synchronizer and an edge detector, so holding it high gives a single step.

Top module: `chord_arp`

## Requirements
- R1: While rst_ni is low, and after it is released, the sequencer is in the root state (tone_o = 0) and note_o equals root_i.
- R2: tone_o codes are root 0, ascending third 1, ascending fifth 2, upper 3, descending fifth 4, descending third 5. The offset added to the root is 0 for the root, 4 for a third (3 when minor_i is 1), 7 for a fifth and 11 for the upper tone (12 when octave_i is 1).
- R3: If root plus offset exceeds 127, note_o is 127.
- R4: With descend_i low, each step moves to the next higher enabled tone, in the order third, fifth, upper. After the highest enabled tone the next step goes back to the root.
- R5: With descend_i high, the step after the highest enabled tone goes to the enabled lower tones in descending order: the fifth (code 4) and then the third (code 5). The step after that goes to the root. The top tone and the root are never visited twice in a row.
- R6: With the third, fifth and upper tone all disabled, every step leaves the sequencer on the root.
- R7: Each rising edge of adv_i gives exactly one step, however long adv_i stays high. No step happens while adv_i stays high or stays low.
- R8: If the tone of the current state has been disabled, the next step goes to the next enabled tone in the current direction, or to the root if there is none.
- R9: A change of minor_i, octave_i or root_i changes note_o without changing tone_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| adv_i | input | 1 | Advance pulse; may be asynchronous to clk_i |
| root_i | input | 7 | Root note code |
| third_en_i | input | 1 | Enables the third |
| fifth_en_i | input | 1 | Enables the fifth |
| upper_en_i | input | 1 | Enables the upper tone |
| minor_i | input | 1 | 1 selects a minor third |
| octave_i | input | 1 | 1 selects an octave instead of a seventh |
| descend_i | input | 1 | 1 selects up-down mode |
| tone_o | output | 3 | Code of the current state |
| note_o | output | 7 | Output note code |

## Verification
The cycle is run with several enable patterns: third and upper only, all three tones, fifth alone, and none. Each pattern is run in both modes. Comparing the two modes shows whether the turnaround repeats the top tone or the root. The single-tone and no-tone patterns show whether the wrap-around and the idle root are handled.

Tones are disabled in the middle of a cycle to test the skip rule. The two selects and a high root are used to test the offsets and the clamp. Long and short advance pulses show whether a level is being taken for an edge.

// File: rtl/arp_pkg.sv
package arp_pkg;
  typedef enum logic [2:0] {
    ST_ROOT     = 3'd0,
    ST_THIRD_UP = 3'd1,
    ST_FIFTH_UP = 3'd2,
    ST_UPPER    = 3'd3,
    ST_FIFTH_DN = 3'd4,
    ST_THIRD_DN = 3'd5
  } tone_e;

  localparam int unsigned OFS_MIN3 = 3;
  localparam int unsigned OFS_MAJ3 = 4;
  localparam int unsigned OFS_FIFTH = 7;
  localparam int unsigned OFS_SEV  = 11;
  localparam int unsigned OFS_OCT  = 12;
endpackage

// File: rtl/arp_edge_sync.sv
module arp_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= pulse_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[STAGES-2:0], pulse_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  // R7
  single_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/arp_fsm.sv
module arp_fsm
  import arp_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  step_i,
  input  logic  third_en_i,
  input  logic  fifth_en_i,
  input  logic  upper_en_i,
  input  logic  descend_i,
  output tone_e state_o
);
  tone_e state_q, state_d, after_top;

  // descent entry once the highest enabled tone has been played
  always_comb begin
    if (descend_i && fifth_en_i)      after_top = ST_FIFTH_DN;
    else if (descend_i && third_en_i) after_top = ST_THIRD_DN;
    else                              after_top = ST_ROOT;
  end

  always_comb begin
    state_d = state_q;
    if (step_i) begin
      unique case (state_q)
        ST_ROOT:
          if (third_en_i)      state_d = ST_THIRD_UP;
          else if (fifth_en_i) state_d = ST_FIFTH_UP;
          else if (upper_en_i) state_d = ST_UPPER;
          else                 state_d = ST_ROOT;
        ST_THIRD_UP:
          if (fifth_en_i)      state_d = ST_FIFTH_UP;
          else if (upper_en_i) state_d = ST_UPPER;
          else                 state_d = ST_ROOT;
        ST_FIFTH_UP:
          if (upper_en_i)                   state_d = ST_UPPER;
          else if (descend_i && third_en_i) state_d = ST_THIRD_DN;
          else                              state_d = ST_ROOT;
        ST_UPPER:
          state_d = after_top;
        ST_FIFTH_DN:
          state_d = (descend_i && third_en_i) ? ST_THIRD_DN : ST_ROOT;
        default:
          state_d = ST_ROOT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_q <= ST_ROOT;
    else         state_q <= state_d;

  assign state_o = state_q;

  // R7
  hold_without_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(state_q));
  // R2
  legal_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q <= ST_THIRD_DN);
  // R6
  idle_root_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !third_en_i && !fifth_en_i && !upper_en_i) |=> state_q == ST_ROOT);
  // R4
  wrap_after_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !descend_i && state_q == ST_UPPER) |=> state_q == ST_ROOT);
  // R5
  no_dn_in_asc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !descend_i) |=> !(state_q inside {ST_FIFTH_DN, ST_THIRD_DN}));
endmodule

// File: rtl/arp_note.sv
module arp_note
  import arp_pkg::*;
#(
  parameter int unsigned NOTE_W = 7
) (
  input  logic [NOTE_W-1:0] root_i,
  input  tone_e             tone_i,
  input  logic              minor_i,
  input  logic              octave_i,
  output logic [NOTE_W-1:0] note_o
);
  localparam int unsigned SUM_W = NOTE_W + 1;
  localparam logic [SUM_W-1:0] NOTE_MAX = SUM_W'((1 << NOTE_W) - 1);

  logic [SUM_W-1:0] ofs, sum;

  always_comb begin
    unique case (tone_i)
      ST_THIRD_UP, ST_THIRD_DN: ofs = SUM_W'(minor_i ? OFS_MIN3 : OFS_MAJ3);
      ST_FIFTH_UP, ST_FIFTH_DN: ofs = SUM_W'(OFS_FIFTH);
      ST_UPPER:                 ofs = SUM_W'(octave_i ? OFS_OCT : OFS_SEV);
      default:                  ofs = '0;
    endcase
    sum = {1'b0, root_i} + ofs;
  end

  assign note_o = (sum > NOTE_MAX) ? NOTE_MAX[NOTE_W-1:0] : sum[NOTE_W-1:0];
endmodule

// File: rtl/chord_arp.sv
module chord_arp
  import arp_pkg::*;
#(
  parameter int unsigned NOTE_W      = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [NOTE_W-1:0] root_i,
  input  logic              third_en_i,
  input  logic              fifth_en_i,
  input  logic              upper_en_i,
  input  logic              minor_i,
  input  logic              octave_i,
  input  logic              descend_i,
  output logic [2:0]        tone_o,
  output logic [NOTE_W-1:0] note_o
);
  logic  step;
  tone_e state;

  arp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pulse_i(adv_i),
    .rise_o (step)
  );

  arp_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step),
    .third_en_i(third_en_i),
    .fifth_en_i(fifth_en_i),
    .upper_en_i(upper_en_i),
    .descend_i (descend_i),
    .state_o   (state)
  );

  arp_note #(.NOTE_W(NOTE_W)) u_note (
    .root_i  (root_i),
    .tone_i  (state),
    .minor_i (minor_i),
    .octave_i(octave_i),
    .note_o  (note_o)
  );

  assign tone_o = state;

  // R2
  note_not_below_root_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    note_o >= root_i);
  // R1
  root_tone_note_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tone_o == 3'd0) |-> note_o == root_i);
endmodule

// File: tb/chord_arp_bench.sv
module chord_arp_bench;
  typedef struct {
    string      req;
    logic [2:0] tone;
    logic [6:0] note;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       adv = 1'b0;
  logic [6:0] root = 7'd60;
  logic       t_en = 1'b0, f_en = 1'b0, u_en = 1'b0;
  logic       minor = 1'b0, octv = 1'b0, desc = 1'b0;
  logic [2:0] tone;
  logic [6:0] note;

  int   checks = 0, errors = 0;
  exp_t q[$];
  logic [2:0] m_st = 3'd0;

  always #2 clk = ~clk;

  chord_arp u_chord_arp (
    .clk_i(clk), .rst_ni(rst_ni), .adv_i(adv), .root_i(root),
    .third_en_i(t_en), .fifth_en_i(f_en), .upper_en_i(u_en),
    .minor_i(minor), .octave_i(octv), .descend_i(desc),
    .tone_o(tone), .note_o(note)
  );

  function automatic logic [6:0] exp_note(logic [2:0] st);
    int s;
    case (st)
      3'd1, 3'd5: s = root + (minor ? 3 : 4);
      3'd2, 3'd4: s = root + 7;
      3'd3:       s = root + (octv ? 12 : 11);
      default:    s = root;
    endcase
    return (s > 127) ? 7'd127 : 7'(s);
  endfunction

  // reference stepping per R4, R5, R6, R8
  function automatic logic [2:0] exp_next(logic [2:0] st);
    logic [2:0] dn;
    dn = (desc && f_en) ? 3'd4 : (desc && t_en) ? 3'd5 : 3'd0;
    case (st)
      3'd0: return t_en ? 3'd1 : f_en ? 3'd2 : u_en ? 3'd3 : 3'd0;
      3'd1: return f_en ? 3'd2 : u_en ? 3'd3 : 3'd0;
      3'd2: return u_en ? 3'd3 : (desc && t_en) ? 3'd5 : 3'd0;
      3'd3: return dn;
      3'd4: return (desc && t_en) ? 3'd5 : 3'd0;
      default: return 3'd0;
    endcase
  endfunction

  task automatic expect_now(string req);
    exp_t e;
    e.req = req; e.tone = m_st; e.note = exp_note(m_st);
    q.push_back(e);
    repeat (2) @(negedge clk);
  endtask

  task automatic step(string req, int hold = 4);
    m_st = exp_next(m_st);
    @(negedge clk); adv = 1'b1;
    repeat (hold) @(negedge clk);
    adv = 1'b0;
    repeat (5) @(negedge clk);
    expect_now(req);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk); rst_ni = 1'b1;
    m_st = 3'd0;
    @(negedge clk);
  endtask

  // monitor
  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (tone !== e.tone || note !== e.note) begin
        errors++;
        $display("FAIL %s: tone=%0d note=%0d expected tone=%0d note=%0d",
                 e.req, tone, note, e.tone, e.note);
      end
    end
  end

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_now("R1 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    expect_now("R1 after reset");

    // R4: third+upper ascending: 1,3,0,1,3
    t_en = 1; u_en = 1;
    step("R4"); step("R4"); step("R4"); step("R4"); step("R4");
    if (m_st != 3'd3) $display("bench model mismatch");

    // R5: third+upper up-down: 1,3,5,0
    do_reset(); desc = 1;
    step("R5"); step("R5"); step("R5"); step("R5");

    // R2 R5: all tones, minor, octave, up-down: 1,2,3,4,5,0
    do_reset(); f_en = 1; minor = 1; octv = 1;
    for (int i = 0; i < 7; i++) step("R2 R5 all tones");

    // R4: fifth only ascending
    do_reset(); desc = 0; t_en = 0; u_en = 0; minor = 0; octv = 0;
    step("R4 fifth only"); step("R4 fifth only"); step("R4 fifth only");

    // R6: nothing enabled
    do_reset(); f_en = 0;
    step("R6"); step("R6"); step("R6 up-down"); desc = 1; step("R6 up-down");
    desc = 0;

    // R8: disable current tone mid-cycle
    do_reset(); t_en = 1; f_en = 1; u_en = 1;
    step("R8 setup");
    t_en = 0; step("R8 third disabled");
    f_en = 0; u_en = 0; step("R8 all disabled");

    // R9: select and root changes without a step
    do_reset(); t_en = 1;
    step("R9 setup");
    minor = 1; expect_now("R9 minor");
    root = 7'd48; expect_now("R9 root");
    minor = 0; expect_now("R9 major");

    // R3: clamp near top
    do_reset(); root = 7'd120; f_en = 1; u_en = 1; octv = 1;
    step("R3 third"); step("R3 fifth"); step("R3 octave clamp");
    octv = 0; expect_now("R3 seventh clamp");

    // R7: long hold gives one step; idle gives none
    do_reset(); root = 7'd60; octv = 0;
    step("R7 long hold", 12);
    repeat (10) @(negedge clk);
    expect_now("R7 idle low");
    step("R7 short pulse", 1);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule